// File: doc/BRIEF.md
# Single-outstanding priority interrupt arbiter

This block decides which pending interrupt source is offered to the processor. It allows only one offer at a time. The offer carries a 12-bit value: the source's 4-bit priority in bits 11:8 and its 8-bit source number in bits 7:0. The offer leaves on one of two outputs. The fast output is used when a programmable fast-vector register is enabled and names the offered source. Every other offer leaves on the normal output. The pending flags are level inputs, owned by edge or level detection logic outside the block. That logic also clears the flag of a source once it has been acknowledged.

A source whose pending flag rises while nothing is offered and no scan is running is offered at once. No priority is involved on that path. When several sources rise together, the lowest number wins. An acknowledge withdraws the offer and starts a pipelined scan of a snapshot taken at the acknowledge edge. The scan finds the enabled pending source with the strictly highest non-zero priority and offers it. Each source reaches its priority through a group map fixed at build time. Sources that rise while a scan is running are held. If the scan finds nothing, they are offered in the following cycle.

The offer behaves as a stream beat with the acknowledge acting as ready. While an offer is up (`cur_vld` high), its value and its output side stay unchanged until `ack` is sampled high. An `ack` with no offer up has no effect. The fast-vector register sits behind a small access port that honours only 16-bit accesses.

Top module: `irq_arb`

## Requirements
- R1: After reset no offer is up: `cur_vld`, `nrm_vld` and `fst_vld` are 0, `nrm_val`, `fst_val` and `cur_src` are 0, and the fast-vector register reads 0.
- R2: At most one offer is up at a time. While it is up, `cur_src`, the value and the output side do not change until `ack` is high at a clock edge. An `ack` while no offer is up changes nothing. Outside an offer, `cur_src` is 0.
- R3: The value is {priority[3:0], source[7:0]}. It appears on `nrm_val`, or on `fst_val` under R8, and is 0 on any output that is not valid. Source 0 is never offered. When no offer is up and no scan runs, a source whose `pend` bit was 0 in the previous cycle and is 1 at this edge is offered at this same edge. Its priority can be any value, 0 included. Among such sources rising together, the lowest number wins.
- R4: Source n is eligible, on both the rising path and the scan path, only while bit n of `en` is set. Bit n is bit n mod 8 of enable byte n/8. A rising source that is disabled is dropped.
- R5: The priority of source n is field `prio_regs[4g+3:4g]`, where g is its group. With the default map, g = n/2.
- R6: An acknowledged offer is withdrawn at the `ack` edge, so `cur_vld` is low after that edge. That edge also takes a snapshot of `pend`, `en` and `prio_regs`, and the scan works on it. The winner is the enabled, pending, non-zero source other than the acknowledged one with the strictly greatest priority. Priority 0 never wins, and a tie goes to the lower number. The winner is offered at the edge log2(N_SRC) edges after the `ack` edge, which is 5 edges with the defaults.
- R7: If the scan has no winner, nothing is offered by it. Sources that rose at any edge from the `ack` edge through the scan's last edge are held. They are treated as rising at the next edge, under R3 and R4.
- R8: The fast-vector register has an enable in bit 15 and a vector in bits 7:0. The register is checked at the edge where an offer is made. If the enable is set and the vector equals the source number, that offer is on `fst_vld`/`fst_val` and `nrm_vld` is 0. Otherwise it is on `nrm_vld`/`nrm_val`.
- R9: A write with `fr_wide` = 1 stores `fr_wdata` with every bit except 15 and 7:0 forced to 0. A write with `fr_wide` = 0 is ignored. `fr_rdata` shows the register while `fr_rd` and `fr_wide` are both 1. It shows 16'hFFFF while `fr_rd` is 1 and `fr_wide` is 0, and 0 while `fr_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend | input | N_SRC | Pending flag per source |
| en | input | N_SRC | Enable per source; bit n is bit n mod 8 of byte n/8 |
| prio_regs | input | N_GRP*4 | 4-bit priority per group, group g in bits 4g+3:4g |
| ack | input | 1 | Acknowledge of the current offer (ready) |
| fr_wr | input | 1 | Fast-vector register write strobe |
| fr_rd | input | 1 | Fast-vector register read strobe |
| fr_wide | input | 1 | Access size: 1 = 16-bit, 0 = 8-bit |
| fr_wdata | input | 16 | Write data |
| fr_rdata | output | 16 | Read data |
| nrm_vld | output | 1 | Normal offer valid |
| nrm_val | output | 12 | Normal offer value {priority, source} |
| fst_vld | output | 1 | Fast offer valid |
| fst_val | output | 12 | Fast offer value {priority, source} |
| cur_vld | output | 1 | An offer is outstanding |
| cur_src | output | 8 | Number of the outstanding source |

## Verification
A rising-path offer is visible right after the edge at which its flag is first seen high. A scan result is visible after the fifth edge counted from the `ack` edge. Sources held through an empty scan are offered one edge after that. The bench drives inputs on falling edges and compares every output with a behavioural model on the next falling edge. In each directed step it counts exactly that many falling edges before checking, and it also checks the quiet cycles in between. Fast-register reads are combinational, so they are compared in the same half cycle as the read strobe.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int SRC_DEF  = 32;
  localparam int GRP_DEF  = 16;
  localparam int GRPW_DEF = $clog2(GRP_DEF);

  // Default source-to-group map: two neighbouring sources share one group.
  function automatic logic [SRC_DEF*GRPW_DEF-1:0] pair_map();
    logic [SRC_DEF*GRPW_DEF-1:0] m;
    m = '0;
    for (int n = 0; n < SRC_DEF; n++) begin
      m[n*GRPW_DEF +: GRPW_DEF] = GRPW_DEF'(n / 2);
    end
    return m;
  endfunction

  localparam logic [15:0] FAST_KEEP = 16'h80FF;

endpackage

// File: rtl/arb_max_tree.sv
// Registered binary tree that returns the index of the greatest priority.
// A node takes its right child only when the right priority is strictly
// greater, so ties keep the lower index. Latency is log2(N) cycles.
module arb_max_tree #(
  parameter int N  = 32,
  parameter int PW = 4,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*PW-1:0] in_prio,
  output logic [PW-1:0]   out_prio,
  output logic [IW-1:0]   out_idx
);

  // Heap node j (1..N-1) is stored at index j-1.
  logic [PW-1:0] np [N-1];
  logic [IW-1:0] ni [N-1];

  for (genvar j = 1; j < N; j++) begin : g_node
    logic [PW-1:0] pa, pb;
    logic [IW-1:0] ia, ib;
    if (2 * j >= N) begin : g_leafkids
      assign pa = in_prio[(2*j-N)*PW +: PW];
      assign pb = in_prio[(2*j+1-N)*PW +: PW];
      assign ia = IW'(2*j-N);
      assign ib = IW'(2*j+1-N);
    end else begin : g_nodekids
      assign pa = np[2*j-1];
      assign pb = np[2*j];
      assign ia = ni[2*j-1];
      assign ib = ni[2*j];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        np[j-1] <= '0;
        ni[j-1] <= '0;
      end else if (pb > pa) begin
        np[j-1] <= pb;
        ni[j-1] <= ib;
      end else begin
        np[j-1] <= pa;
        ni[j-1] <= ia;
      end
    end
  end

  assign out_prio = np[0];
  assign out_idx  = ni[0];

endmodule

// File: rtl/arb_low_pick.sv
// Lowest-numbered set bit of a request vector.
module arb_low_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/arb_fast_reg.sv
// Fast-vector register with a 16-bit-only access rule.
module arb_fast_reg
  import icu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fr_wr,
  input  logic        fr_rd,
  input  logic        fr_wide,
  input  logic [15:0] fr_wdata,
  output logic [15:0] fr_rdata,
  output logic [15:0] fir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fir_q <= '0;
    end else if (fr_wr && fr_wide) begin
      fir_q <= fr_wdata & FAST_KEEP;
    end
  end

  always_comb begin
    if (!fr_rd) begin
      fr_rdata = '0;
    end else if (fr_wide) begin
      fr_rdata = fir_q;
    end else begin
      fr_rdata = '1;
    end
  end

endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import icu_pkg::*;
#(
  parameter int N_SRC  = SRC_DEF,
  parameter int N_GRP  = GRP_DEF,
  parameter int PRIO_W = 4,
  parameter logic [N_SRC*$clog2(N_GRP)-1:0] GROUP_MAP = pair_map()
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        en,
  input  logic [N_GRP*PRIO_W-1:0] prio_regs,
  input  logic                    ack,
  input  logic                    fr_wr,
  input  logic                    fr_rd,
  input  logic                    fr_wide,
  input  logic [15:0]             fr_wdata,
  output logic [15:0]             fr_rdata,
  output logic                    nrm_vld,
  output logic [PRIO_W+7:0]       nrm_val,
  output logic                    fst_vld,
  output logic [PRIO_W+7:0]       fst_val,
  output logic                    cur_vld,
  output logic [7:0]              cur_src
);

  localparam int GW   = $clog2(N_GRP);
  localparam int IW   = $clog2(N_SRC);
  localparam int LVLS = IW;
  localparam int CW   = $clog2(LVLS + 1);

  // Offer state
  logic              out_vld;
  logic [IW-1:0]     out_src;
  logic [PRIO_W-1:0] out_prio;
  logic              out_fast;
  // Scan state
  logic              busy;
  logic [CW-1:0]     cnt;
  logic [N_SRC-1:0]  held;
  logic [N_SRC-1:0]  pend_q;

  logic [15:0]       fir_q;

  // Per-source priority through the group map
  logic [PRIO_W-1:0]       src_prio [N_SRC];
  logic [N_SRC*PRIO_W-1:0] leaf_p;

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    assign src_prio[n] = prio_regs[GROUP_MAP[n*GW +: GW]*PRIO_W +: PRIO_W];
    if (n == 0) begin : g_zero
      assign leaf_p[0 +: PRIO_W] = '0;
    end else begin : g_real
      assign leaf_p[n*PRIO_W +: PRIO_W] =
        (pend[n] && en[n] && !(out_vld && out_src == IW'(n))) ? src_prio[n] : '0;
    end
  end

  logic [PRIO_W-1:0] win_prio;
  logic [IW-1:0]     win_idx;

  arb_max_tree #(.N(N_SRC), .PW(PRIO_W), .IW(IW)) i_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_prio  (leaf_p),
    .out_prio (win_prio),
    .out_idx  (win_idx)
  );

  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] cand;
  logic             low_hit;
  logic [IW-1:0]    low_idx;

  assign rise = pend & ~pend_q;
  assign cand = (rise | held) & en & ~N_SRC'(1);

  arb_low_pick #(.N(N_SRC), .IW(IW)) i_low (
    .req (cand),
    .hit (low_hit),
    .idx (low_idx)
  );

  arb_fast_reg i_fast (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_wr    (fr_wr),
    .fr_rd    (fr_rd),
    .fr_wide  (fr_wide),
    .fr_wdata (fr_wdata),
    .fr_rdata (fr_rdata),
    .fir_q    (fir_q)
  );

  logic              ack_take;
  logic              scan_done;
  logic              scan_win;
  logic [IW-1:0]     iss_src;
  logic [PRIO_W-1:0] iss_prio;
  logic              fast_hit;

  assign ack_take  = ack && out_vld;
  assign scan_done = busy && (cnt == CW'(LVLS));
  assign scan_win  = scan_done && (win_prio != '0);
  assign iss_src   = busy ? win_idx : low_idx;
  assign iss_prio  = busy ? win_prio : src_prio[low_idx];
  assign fast_hit  = fir_q[15] && (fir_q[7:0] == 8'(iss_src));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_src  <= '0;
      out_prio <= '0;
      out_fast <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      held     <= '0;
      pend_q   <= '0;
    end else begin
      pend_q <= pend;
      if (ack_take) begin
        out_vld <= 1'b0;
        busy    <= 1'b1;
        cnt     <= CW'(1);
        held    <= held | rise;
      end else if (busy) begin
        if (scan_done) begin
          busy <= 1'b0;
          cnt  <= '0;
          if (scan_win) begin
            out_vld  <= 1'b1;
            out_src  <= iss_src;
            out_prio <= iss_prio;
            out_fast <= fast_hit;
            held     <= '0;
          end else begin
            held <= held | rise;
          end
        end else begin
          cnt  <= cnt + CW'(1);
          held <= held | rise;
        end
      end else if (!out_vld) begin
        held <= '0;
        if (low_hit) begin
          out_vld  <= 1'b1;
          out_src  <= iss_src;
          out_prio <= iss_prio;
          out_fast <= fast_hit;
        end
      end
    end
  end

  assign cur_vld = out_vld;
  assign cur_src = out_vld ? 8'(out_src) : 8'd0;
  assign nrm_vld = out_vld && !out_fast;
  assign fst_vld = out_vld && out_fast;
  assign nrm_val = nrm_vld ? {out_prio, 8'(out_src)} : '0;
  assign fst_val = fst_vld ? {out_prio, 8'(out_src)} : '0;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          nrm_vld,
  input logic [VW-1:0] nrm_val,
  input logic          fst_vld,
  input logic [VW-1:0] fst_val,
  input logic          cur_vld,
  input logic [7:0]    cur_src,
  input logic          fr_wr,
  input logic          fr_rd,
  input logic          fr_wide,
  input logic [15:0]   fr_rdata,
  input logic [15:0]   fir_q
);

  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(nrm_vld && fst_vld));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && !ack) |=> (cur_vld && $stable(cur_src) && $stable(nrm_val) && $stable(fst_val)));

  a_r6_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && ack) |=> (!cur_vld && !nrm_vld && !fst_vld));

  a_r3_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vld |-> (cur_src != 8'd0));

  a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_vld |-> (nrm_val[7:0] == cur_src));

  a_r8_fast_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fst_vld) |-> ($past(fir_q[15]) && ($past(fir_q[7:0]) == fst_val[7:0])));

  a_r8_normal_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nrm_vld) |-> !($past(fir_q[15]) && ($past(fir_q[7:0]) == nrm_val[7:0])));

  a_r9_narrow_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_wr && !fr_wide) |=> $stable(fir_q));

  a_r9_narrow_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_rd && !fr_wide) |-> (fr_rdata == 16'hFFFF));

endmodule

bind irq_arb irq_arb_chk #(.VW(PRIO_W + 8)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .nrm_vld  (nrm_vld),
  .nrm_val  (nrm_val),
  .fst_vld  (fst_vld),
  .fst_val  (fst_val),
  .cur_vld  (cur_vld),
  .cur_src  (cur_src),
  .fr_wr    (fr_wr),
  .fr_rd    (fr_rd),
  .fr_wide  (fr_wide),
  .fr_rdata (fr_rdata),
  .fir_q    (fir_q)
);

// File: tb/test_irq_arb.sv
`timescale 1ns/1ps
module test_irq_arb;

  localparam int CLK_P = 10;
  localparam int NS    = 32;
  localparam int NG    = 16;
  localparam int LAT   = 5;   // log2(NS) scan edges

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] pend = '0;
  logic [NS-1:0] en = '0;
  logic [NG*4-1:0] prio_regs = '0;
  logic          ack = 1'b0;
  logic          fr_wr = 1'b0, fr_rd = 1'b0, fr_wide = 1'b0;
  logic [15:0]   fr_wdata = '0;
  logic [15:0]   fr_rdata;
  logic          nrm_vld, fst_vld, cur_vld;
  logic [11:0]   nrm_val, fst_val;
  logic [7:0]    cur_src;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_arb i_irq_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .prio_regs(prio_regs),
    .ack(ack), .fr_wr(fr_wr), .fr_rd(fr_rd), .fr_wide(fr_wide),
    .fr_wdata(fr_wdata), .fr_rdata(fr_rdata), .nrm_vld(nrm_vld),
    .nrm_val(nrm_val), .fst_vld(fst_vld), .fst_val(fst_val),
    .cur_vld(cur_vld), .cur_src(cur_src)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_vld, m_fast, m_busy;
  int          m_src, m_prio, m_cnt, m_wsrc, m_wprio;
  bit [NS-1:0] m_held, m_pq;
  bit [15:0]   m_fir;

  function automatic int prio_of(int n);
    return int'(prio_regs[(n/2)*4 +: 4]);   // R5 default map g = n/2
  endfunction

  task automatic m_issue(int s, int p);
    m_vld  = 1'b1;
    m_src  = s;
    m_prio = p;
    m_fast = m_fir[15] && (int'(m_fir[7:0]) == s);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_fast = 0; m_busy = 0; m_src = 0; m_prio = 0; m_cnt = 0;
      m_held = '0; m_pq = '0; m_fir = '0; m_wsrc = 0; m_wprio = 0;
    end else begin
      bit [NS-1:0] rise;
      bit [NS-1:0] cand;
      rise = pend & ~m_pq;
      if (m_vld && ack) begin
        m_wprio = 0; m_wsrc = 0;
        for (int n = 1; n < NS; n++)
          if (pend[n] && en[n] && n != m_src && prio_of(n) > m_wprio) begin
            m_wprio = prio_of(n); m_wsrc = n;
          end
        m_vld = 0; m_busy = 1; m_cnt = 1; m_held = m_held | rise;
      end else if (m_busy) begin
        if (m_cnt == LAT) begin
          m_busy = 0;
          if (m_wprio > 0) begin m_issue(m_wsrc, m_wprio); m_held = '0; end
          else m_held = m_held | rise;
        end else begin
          m_cnt++; m_held = m_held | rise;
        end
      end else if (!m_vld) begin
        cand = (rise | m_held) & en;
        cand[0] = 1'b0;
        m_held = '0;
        for (int n = 0; n < NS; n++)
          if (cand[n]) begin m_issue(n, prio_of(n)); break; end
      end
      if (fr_wr && fr_wide) m_fir = fr_wdata & 16'h80FF;
      m_pq = pend;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ev;
    int rd;
    ev = (m_prio << 8) | m_src;
    rd = !fr_rd ? 0 : (fr_wide ? int'(m_fir) : 16'hFFFF);
    chk("R2 cur_vld", int'(cur_vld), int'(m_vld));
    chk("R2 cur_src", int'(cur_src), m_vld ? m_src : 0);
    chk("R3 nrm_vld", int'(nrm_vld), int'(m_vld && !m_fast));
    chk("R3 nrm_val", int'(nrm_val), (m_vld && !m_fast) ? ev : 0);
    chk("R8 fst_vld", int'(fst_vld), int'(m_vld && m_fast));
    chk("R8 fst_val", int'(fst_val), (m_vld && m_fast) ? ev : 0);
    chk("R9 fr_rdata", int'(fr_rdata), rd);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic steps(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) prio_regs[g*4 +: 4] = 4'(g);
    steps(2);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 cur_vld", int'(cur_vld), 0);
    chk("R1 nrm_val", int'(nrm_val), 0);
    chk("R1 fst_vld", int'(fst_vld), 0);
    fr_rd = 1; fr_wide = 1;
    step();
    chk("R1 fast reg", int'(fr_rdata), 0);

    // R9 access rules
    fr_rd = 0; fr_wr = 1; fr_wdata = 16'hFFFF;
    step();
    fr_wr = 0; fr_rd = 1;
    step();
    chk("R9 wide write", int'(fr_rdata), 16'h80FF);
    fr_wr = 1; fr_wide = 0; fr_rd = 0; fr_wdata = 16'h1234;
    step();
    fr_wr = 0; fr_rd = 1; fr_wide = 1;
    step();
    chk("R9 narrow write ignored", int'(fr_rdata), 16'h80FF);
    fr_wide = 0;
    step();
    chk("R9 narrow read", int'(fr_rdata), 16'hFFFF);
    fr_rd = 0; fr_wr = 1; fr_wide = 1; fr_wdata = 16'h0000;
    step();
    fr_wr = 0;

    // R3 / R5 rising path
    en = '1;
    pend[5] = 1;
    step();
    chk("R3 rise offer", int'(nrm_val), {4'd2, 8'd5});
    // R2 risers while outstanding do not displace the offer
    pend[8] = 1; pend[9] = 1;
    step();
    chk("R2 held offer", int'(cur_src), 5);
    // R2 acknowledge with nothing up is ignored later; now ack source 5
    ack = 1; pend[5] = 0;
    step();
    ack = 0;
    chk("R6 withdrawn", int'(cur_vld), 0);
    steps(4);
    chk("R6 not early", int'(cur_vld), 0);
    step();
    chk("R6 tie lowest", int'(nrm_val), {4'd4, 8'd8});

    // R7 empty scan, riser during scan held
    ack = 1; pend[8] = 0;
    step();
    ack = 0;
    steps(LAT);
    chk("R6 second winner", int'(cur_src), 9);
    ack = 1; pend[9] = 0;
    step();
    ack = 0;
    step();
    pend[1] = 1;          // rises during the scan, priority 0
    steps(4);
    chk("R7 empty scan", int'(cur_vld), 0);
    step();
    chk("R7 held riser", int'(nrm_val), {4'd0, 8'd1});

    // R4 disabled high-priority source skipped
    en[30] = 0;
    ack = 1; pend[1] = 0; pend[30] = 1; pend[20] = 1;
    step();
    ack = 0;
    steps(LAT);
    chk("R4 disabled skipped", int'(nrm_val), {4'd10, 8'd20});

    // R8 fast steering
    fr_wr = 1; fr_wide = 1; fr_wdata = 16'h8019;
    ack = 1; pend[20] = 0;
    step();
    fr_wr = 0; ack = 0;
    steps(LAT + 1);
    chk("R4 disabled never", int'(cur_vld), 0);
    pend[25] = 1;
    step();
    chk("R8 fast vld", int'(fst_vld), 1);
    chk("R8 fast val", int'(fst_val), {4'd12, 8'd25});
    chk("R8 normal quiet", int'(nrm_vld), 0);

    // R3 source 0 never offered, R2 stray ack
    ack = 1; pend[25] = 0;
    step();
    ack = 0;
    steps(LAT + 1);
    pend[0] = 1;
    step();
    chk("R3 source 0", int'(cur_vld), 0);
    ack = 1;
    step();
    ack = 0;
    chk("R2 stray ack", int'(cur_vld), 0);
    pend = '0; en = '1;
    steps(2);

    // Mixed traffic against the model
    for (int it = 0; it < 4000; it++) begin
      step();
      ack = 0; fr_wr = 0;
      if (cur_vld && ($urandom % 4 == 0)) begin
        ack = 1; pend[cur_src] = 0;
      end
      for (int n = 0; n < NS; n++) begin
        if ($urandom % 24 == 0) pend[n] = 1;
        else if ($urandom % 48 == 0) pend[n] = 0;
      end
      if ($urandom % 50 == 0) en = $urandom | $urandom;
      if ($urandom % 60 == 0) prio_regs = {$urandom, $urandom};
      fr_wide = 1'($urandom % 2);
      fr_rd = 1'($urandom % 2);
      if ($urandom % 30 == 0) begin
        fr_wr = 1;
        fr_wdata = ($urandom % 2) ? (16'h8000 | 16'($urandom % NS)) : 16'($urandom);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule